// File: doc/BRIEF.md
# Interrupt Request Destination Router

This block sits between a set of peripheral interrupt sources and the three agents that can service them: the processor interrupt input, a DMA engine, and a descriptor-driven transfer controller. Each source has a pending flag. A request that finds the flag clear sets it and is steered to one agent, chosen by a per-source destination code. A request that finds the flag already set is lost.

Each source also has an enable bit and a "notify after transfer" bit. Each engine drives a per-source input that reports whether its remaining transfer count is zero. When a source is routed to an engine, these settings decide two things: when the pending flag drops (at transfer start, at controller data start, or at processor acknowledge) and whether a processor interrupt follows the transfer. An engine start that exhausts the count clears the source's transfer-enable bit. Later requests from that source then go to the processor until software writes the destination again.

Software programs each source through a single write port. Each engine, and the processor, reports its events as single-cycle pulses tagged with a source index.

Top module: `irq_dest_router`

## Requirements
- R1: With the enable bit at 1 and a destination code of 0 or 3, or with the transfer-enable bit at 0, a request sets the pending flag and raises `cpu_irq_o` one cycle later. A `cpu_ack_i` pulse for that source clears both.
- R2: A request from a source whose enable bit is 0 leaves its pending flag at 0.
- R3: A request that arrives while the source's pending flag is 1 is dropped. After the acknowledge, the flag stays 0 and no second interrupt appears.
- R4: Destination code 1 is the DMA engine. With the notify bit at 1, a request raises `dma_trig_o`. The start pulse drops the trigger and raises `cpu_irq_o`, and the pending flag stays 1 until the acknowledge.
- R5: With destination code 1, the notify bit at 0 and a nonzero count, the DMA start pulse clears the pending flag, and no processor interrupt follows.
- R6: Destination code 2 is the transfer controller. With the notify bit at 1, a request raises `xfer_trig_o`. The data-start pulse raises `cpu_irq_o`, and the pending flag stays 1 until the acknowledge.
- R7: With destination code 2, the notify bit at 0 and a nonzero count, the controller data-start pulse clears the pending flag, and no processor interrupt follows.
- R8: With destination code 2, the notify bit at 0 and a zero count, the data-start pulse raises `cpu_irq_o` and keeps the pending flag at 1 until the acknowledge. It also clears the transfer-enable bit.
- R9: Any engine start that sees the count at zero clears the transfer-enable bit. This includes a DMA start with the notify bit at 0, which still clears the pending flag at start. After that, the source's requests go to the processor.
- R10: A configuration write to a source whose stored enable bit is 1 leaves its destination and transfer-enable bit unchanged. Its enable and notify fields still take effect. A write to a disabled source stores the destination and sets the transfer-enable bit when the code is 1 or 2.
- R11: If an acknowledge and a new request for the same source arrive in the same cycle, the acknowledge wins. The pending flag goes to 0 and the request is dropped.
- R12: An acknowledge or start pulse is ignored unless its indexed source is currently waiting for that agent.
- R13: After reset, all pending flags, stage outputs and transfer-enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IW | Source index for the write |
| cfg_en_i | input | 1 | Enable bit to store |
| cfg_dest_i | input | 2 | Destination code: 0 CPU, 1 DMA, 2 transfer controller, 3 CPU |
| cfg_after_i | input | 1 | Notify-after-transfer bit to store |
| req_i | input | N_SRC | Request pulse per source |
| cnt_zero_i | input | N_SRC | Remaining count is zero, per source |
| cpu_ack_i | input | 1 | Processor acknowledge pulse |
| cpu_ack_idx_i | input | IW | Source being acknowledged |
| dma_start_i | input | 1 | DMA transfer-start pulse |
| dma_start_idx_i | input | IW | Source whose DMA transfer starts |
| xfer_start_i | input | 1 | Controller data-start pulse |
| xfer_start_idx_i | input | IW | Source whose controller data transfer starts |
| pend_o | output | N_SRC | Pending flags |
| cpu_irq_o | output | N_SRC | Processor interrupt requests |
| dma_trig_o | output | N_SRC | DMA engine triggers |
| xfer_trig_o | output | N_SRC | Transfer controller triggers |
| xfer_en_o | output | N_SRC | Transfer-enable bits |

## Verification
A corrupted stage register shows on the ports one cycle after the event that wrote it. The symptom is a trigger raised to the wrong agent, or a pending flag that stays high or drops early relative to a start or acknowledge pulse. A lost transfer-enable clear stays hidden until the source's next request, which then wakes an engine instead of the processor. For that reason the bench always follows an exhausting start with a fresh request. A misrouted index or a stage check that is too loose shows as a flag that clears on a pulse meant for another agent or another source.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    DEST_CPU     = 2'b00,
    DEST_DMA     = 2'b01,
    DEST_XFER    = 2'b10,
    DEST_CPU_ALT = 2'b11
  } dest_e;
endpackage

// File: rtl/irq_route_dec.sv
module irq_route_dec #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          vld_i,
  input  logic [IW-1:0] idx_i,
  output logic [N-1:0]  hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit_o[g] = vld_i && (idx_i == IW'(g));
  end
endmodule

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     wr_hit_i,
  input  logic             en_d_i,
  input  logic [1:0]       dest_d_i,
  input  logic             after_d_i,
  input  logic [N-1:0]     exhaust_i,
  output logic [N-1:0]     en_o,
  output logic [N-1:0]     after_o,
  output logic [N-1:0]     xen_o,
  output logic [N-1:0][1:0] route_o
);
  logic [N-1:0][1:0] dest_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic dest_ok;
    assign dest_ok = wr_hit_i[g] && !en_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]    <= 1'b0;
        after_o[g] <= 1'b0;
        dest_q[g]  <= DEST_CPU;
        xen_o[g]   <= 1'b0;
      end else begin
        if (wr_hit_i[g]) begin
          en_o[g]    <= en_d_i;
          after_o[g] <= after_d_i;
        end
        // accepted destination write re-arms; otherwise exhaust drops the engine
        if (dest_ok) begin
          dest_q[g] <= dest_d_i;
          xen_o[g]  <= (dest_d_i == DEST_DMA) || (dest_d_i == DEST_XFER);
        end else if (exhaust_i[g]) begin
          xen_o[g]  <= 1'b0;
        end
      end
    end

    always_comb begin
      route_o[g] = DEST_CPU;
      if (xen_o[g] && (dest_q[g] == DEST_DMA))  route_o[g] = DEST_DMA;
      if (xen_o[g] && (dest_q[g] == DEST_XFER)) route_o[g] = DEST_XFER;
    end

    // R10
    dest_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[g] && wr_hit_i[g] |=> $stable(dest_q[g]) && $stable(xen_o[g]));
    // R9
    exhaust_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exhaust_i[g] && !dest_ok |=> !xen_o[g]);
  end
endmodule

// File: rtl/irq_route_slot.sv
module irq_route_slot
  import irq_route_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       en_i,
  input  logic [1:0] route_i,
  input  logic       after_i,
  input  logic       cz_i,
  input  logic       ack_i,
  input  logic       dstart_i,
  input  logic       xstart_i,
  output logic       pend_o,
  output logic       irq_o,
  output logic       dma_o,
  output logic       xfr_o,
  output logic       exhaust_o
);
  logic idle, irq_n, dma_n, xfr_n;

  assign idle = !(irq_o || dma_o || xfr_o);

  always_comb begin
    irq_n     = irq_o;
    dma_n     = dma_o;
    xfr_n     = xfr_o;
    exhaust_o = 1'b0;
    if (irq_o && ack_i) irq_n = 1'b0;
    if (dma_o && dstart_i) begin
      dma_n     = 1'b0;
      irq_n     = after_i;
      exhaust_o = cz_i;
    end
    if (xfr_o && xstart_i) begin
      xfr_n     = 1'b0;
      irq_n     = after_i || cz_i;
      exhaust_o = cz_i;
    end
    // new request only lands on an idle slot; busy slot drops it
    if (idle && req_i && en_i) begin
      unique case (route_i)
        DEST_DMA:  dma_n = 1'b1;
        DEST_XFER: xfr_n = 1'b1;
        default:   irq_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      dma_o  <= 1'b0;
      xfr_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      irq_o  <= irq_n;
      dma_o  <= dma_n;
      xfr_o  <= xfr_n;
      pend_o <= irq_n || dma_n || xfr_n;
    end
  end

  // R13
  stage_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, dma_o, xfr_o}));
  // R2
  disabled_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o && req_i && !en_i |=> !pend_o);
  // R4
  dma_notify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_o && dstart_i && after_i |=> irq_o && pend_o);
  // R5
  dma_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_o && dstart_i && !after_i |=> !pend_o);
  // R7
  xfer_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfr_o && xstart_i && !after_i && !cz_i |=> !pend_o);
  // R8
  xfer_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfr_o && xstart_i && cz_i |=> irq_o && pend_o);
  // R11
  ack_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i && req_i |=> !pend_o);
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic             cfg_en_i,
  input  logic [1:0]       cfg_dest_i,
  input  logic             cfg_after_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] cnt_zero_i,
  input  logic             cpu_ack_i,
  input  logic [IW-1:0]    cpu_ack_idx_i,
  input  logic             dma_start_i,
  input  logic [IW-1:0]    dma_start_idx_i,
  input  logic             xfer_start_i,
  input  logic [IW-1:0]    xfer_start_idx_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] cpu_irq_o,
  output logic [N_SRC-1:0] dma_trig_o,
  output logic [N_SRC-1:0] xfer_trig_o,
  output logic [N_SRC-1:0] xfer_en_o
);
  logic [N_SRC-1:0]      wr_hit, ack_hit, ds_hit, xs_hit;
  logic [N_SRC-1:0]      en, after, exhaust;
  logic [N_SRC-1:0][1:0] route;

  irq_route_dec #(.N(N_SRC), .IW(IW)) u_dec_wr (
    .vld_i(cfg_we_i), .idx_i(cfg_idx_i), .hit_o(wr_hit));
  irq_route_dec #(.N(N_SRC), .IW(IW)) u_dec_ack (
    .vld_i(cpu_ack_i), .idx_i(cpu_ack_idx_i), .hit_o(ack_hit));
  irq_route_dec #(.N(N_SRC), .IW(IW)) u_dec_ds (
    .vld_i(dma_start_i), .idx_i(dma_start_idx_i), .hit_o(ds_hit));
  irq_route_dec #(.N(N_SRC), .IW(IW)) u_dec_xs (
    .vld_i(xfer_start_i), .idx_i(xfer_start_idx_i), .hit_o(xs_hit));

  irq_route_cfg #(.N(N_SRC)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hit_i  (wr_hit),
    .en_d_i    (cfg_en_i),
    .dest_d_i  (cfg_dest_i),
    .after_d_i (cfg_after_i),
    .exhaust_i (exhaust),
    .en_o      (en),
    .after_o   (after),
    .xen_o     (xfer_en_o),
    .route_o   (route)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    irq_route_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[g]),
      .en_i      (en[g]),
      .route_i   (route[g]),
      .after_i   (after[g]),
      .cz_i      (cnt_zero_i[g]),
      .ack_i     (ack_hit[g]),
      .dstart_i  (ds_hit[g]),
      .xstart_i  (xs_hit[g]),
      .pend_o    (pend_o[g]),
      .irq_o     (cpu_irq_o[g]),
      .dma_o     (dma_trig_o[g]),
      .xfr_o     (xfer_trig_o[g]),
      .exhaust_o (exhaust[g])
    );
  end

  // R12
  ack_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_i && !cpu_irq_o[cpu_ack_idx_i] && !dma_start_i && !xfer_start_i
      && !cfg_we_i && (req_i == '0) |=> $stable(pend_o));
endmodule

// File: tb/tb_irq_dest_router.sv
module tb_irq_dest_router;
  localparam int N = 8;

  typedef struct packed {
    logic [2:0] idx;
    logic [1:0] dest;
    logic       after;
    logic       cz;
    logic [1:0] stage;  // 1 cpu, 2 dma, 3 xfer
    logic       pend_s;
    logic       irq_s;
    logic       xen;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},
    '{3'd1, 2'd3, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},
    '{3'd2, 2'd1, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1},
    '{3'd3, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
    '{3'd4, 2'd2, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},
    '{3'd5, 2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1},
    '{3'd6, 2'd2, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0},
    '{3'd7, 2'd1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
    '{3'd2, 2'd1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cfg_en_i = 1'b0, cfg_after_i = 1'b0;
  logic [2:0] cfg_idx_i = '0;
  logic [1:0] cfg_dest_i = '0;
  logic [N-1:0] req_i = '0, cnt_zero_i = '0;
  logic cpu_ack_i = 1'b0, dma_start_i = 1'b0, xfer_start_i = 1'b0;
  logic [2:0] cpu_ack_idx_i = '0, dma_start_idx_i = '0, xfer_start_idx_i = '0;
  logic [N-1:0] pend_o, cpu_irq_o, dma_trig_o, xfer_trig_o, xfer_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_dest_router #(.N_SRC(N)) dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic en, input logic [1:0] dest, input logic after);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx[2:0]; cfg_en_i = en;
    cfg_dest_i = dest; cfg_after_i = after;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic req(input int idx);
    @(negedge clk_i); req_i[idx] = 1'b1;
    @(negedge clk_i); req_i = '0;
  endtask

  task automatic ack(input int idx);
    @(negedge clk_i); cpu_ack_i = 1'b1; cpu_ack_idx_i = idx[2:0];
    @(negedge clk_i); cpu_ack_i = 1'b0;
  endtask

  task automatic dstart(input int idx);
    @(negedge clk_i); dma_start_i = 1'b1; dma_start_idx_i = idx[2:0];
    @(negedge clk_i); dma_start_i = 1'b0;
  endtask

  task automatic xstart(input int idx);
    @(negedge clk_i); xfer_start_i = 1'b1; xfer_start_idx_i = idx[2:0];
    @(negedge clk_i); xfer_start_i = 1'b0;
  endtask

  function automatic string vtag(input int k);
    case (k)
      0, 1: return "R1";
      2, 8: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk("R13 pend", |pend_o, 1'b0);
    chk("R13 stage", |{cpu_irq_o, dma_trig_o, xfer_trig_o}, 1'b0);
    chk("R13 xen", |xfer_en_o, 1'b0);
    rst_ni = 1'b1;

    for (int k = 0; k < 9; k++) begin
      vec_t v;
      v = VECS[k];
      cfg_wr(v.idx, 1'b0, v.dest, v.after);
      cfg_wr(v.idx, 1'b1, v.dest, v.after);
      chk({vtag(k), " xen armed"}, xfer_en_o[v.idx], (v.dest == 2'd1) || (v.dest == 2'd2));
      req(v.idx);
      chk({vtag(k), " pend set"}, pend_o[v.idx], 1'b1);
      chk({vtag(k), " cpu stage"}, cpu_irq_o[v.idx], v.stage == 2'd1);
      chk({vtag(k), " dma stage"}, dma_trig_o[v.idx], v.stage == 2'd2);
      chk({vtag(k), " xfer stage"}, xfer_trig_o[v.idx], v.stage == 2'd3);
      if (v.stage != 2'd1) begin
        cnt_zero_i[v.idx] = v.cz;
        if (v.stage == 2'd2) dstart(v.idx);
        else xstart(v.idx);
        cnt_zero_i = '0;
        chk({vtag(k), " pend after start"}, pend_o[v.idx], v.pend_s);
        chk({vtag(k), " irq after start"}, cpu_irq_o[v.idx], v.irq_s);
        chk({vtag(k), " xen after start"}, xfer_en_o[v.idx], v.xen);
      end
      if (cpu_irq_o[v.idx]) begin
        ack(v.idx);
        chk({vtag(k), " pend after ack"}, pend_o[v.idx], 1'b0);
      end
    end

    // R9 exhausted DMA source now goes to the processor
    req(7);
    chk("R9 falls back cpu", cpu_irq_o[7], 1'b1);
    chk("R9 no dma", dma_trig_o[7], 1'b0);
    ack(7);

    // R2 disabled source
    cfg_wr(0, 1'b0, 2'd0, 1'b0);
    req(0);
    chk("R2 disabled", pend_o[0], 1'b0);

    // R3 duplicate while pending is dropped
    cfg_wr(0, 1'b1, 2'd0, 1'b0);
    req(0);
    req(0);
    ack(0);
    chk("R3 no requeue pend", pend_o[0], 1'b0);
    chk("R3 no requeue irq", cpu_irq_o[0], 1'b0);

    // R10 destination write locked while enabled
    cfg_wr(0, 1'b1, 2'd1, 1'b0);
    chk("R10 xen unchanged", xfer_en_o[0], 1'b0);
    req(0);
    chk("R10 still cpu", cpu_irq_o[0], 1'b1);
    chk("R10 no dma", dma_trig_o[0], 1'b0);

    // R11 ack and request together: ack wins
    @(negedge clk_i);
    cpu_ack_i = 1'b1; cpu_ack_idx_i = 3'd0; req_i[0] = 1'b1;
    @(negedge clk_i);
    cpu_ack_i = 1'b0; req_i = '0;
    chk("R11 pend", pend_o[0], 1'b0);
    chk("R11 irq", cpu_irq_o[0], 1'b0);

    // R12 mismatched pulses ignored
    req(3);
    chk("R12 dma stage", dma_trig_o[3], 1'b1);
    ack(3);
    chk("R12 ack ignored", dma_trig_o[3], 1'b1);
    xstart(3);
    chk("R12 xstart ignored", pend_o[3], 1'b1);
    dstart(4);
    chk("R12 other idx", dma_trig_o[3], 1'b1);
    chk("R12 idle src", pend_o[4], 1'b0);
    dstart(3);
    chk("R12 right start", pend_o[3], 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule